// File: doc/BRIEF.md
# Parallel Bus Register Interface

This block is the host-facing side of a multi-channel converter. A processor reaches it over an asynchronous parallel bus that has active-low select, write and read strobes and a 10-bit data bus. A write stores a 10-bit control word, which software cannot read back, and asks the conversion sequencer to begin a new sequence. A read places one of two conversion results on the bus. The block picks the result from the conversion mode and from an internal pointer that alternates between the two results.

The three strobes are brought into the system clock domain through a synchroniser chain, and edges are detected on the synchronised copies. An access that arrives while the sequencer reports a conversion in progress produces a one-cycle abort request. The active-low status output has two modes. It can mirror the conversion-in-progress input, or it can act as a latched interrupt. The interrupt is raised by the sequencer's completion pulse and cleared by the start of any selected bus access. The data bus is modelled as separate input and output vectors plus an output enable.

Top module: `parbus_host_if`

## Requirements
- R1: After reset the control word is all zeros, the status output is high and the output enable is low.
- R2: With select low, the rising edge of the write strobe loads the data bus into the control word, and a single one-cycle start pulse is issued for each such write. The control word changes in no other cycle.
- R3: While select is high, the output enable stays low, and write or read strobes neither change the control word nor issue a start pulse.
- R4: While select and read are both low, the output enable is high and the bus carries a conversion result. The result is passed through unchanged, with no recoding.
- R5: When bit 6 of the control word is 0 (single mode), every read returns result 1.
- R6: When bit 6 is 1 (dual mode), successive reads return result 1, result 2, result 1 and so on, and each write returns the pointer to result 1.
- R7: When bit 9 is 1 (interrupt mode), a completion pulse drives the status output low. It stays low until the falling edge of a read or write strobe with select low, which returns it high.
- R8: When bit 9 is 0 (busy mode), the status output is low exactly while the conversion-in-progress input is high.
- R9: The falling edge of a selected read or write while a conversion is in progress issues exactly one one-cycle abort request. Accesses made while no conversion is running issue none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Bus select, active low |
| wrN | input | 1 | Write strobe, active low |
| rdN | input | 1 | Read strobe, active low |
| busIn | input | 10 | Data bus, inbound |
| busOut | output | 10 | Data bus, outbound |
| busOe | output | 1 | Output enable for the data bus |
| convActive | input | 1 | Sequencer reports a conversion in progress |
| convDone | input | 1 | One-cycle pulse when a conversion sequence completes |
| result1 | input | 10 | First conversion result, two's complement |
| result2 | input | 10 | Second conversion result, two's complement |
| ctrlReg | output | 10 | Current control word, sent to the sequencer |
| startReq | output | 1 | One-cycle request to start a sequence |
| abortReq | output | 1 | One-cycle request to halt the running conversion |
| flagN | output | 1 | Active-low busy or interrupt status |

## Verification
The assertions assume that each strobe stays low and then high for longer than the synchroniser latency. They also assume that select stays low around the whole strobe and that the inbound data holds steady while a write edge is being detected. Under those conditions a start and an abort can never land in the same cycle. The bench meets these conditions by having every access task hold each level for several clocks and leave select low after the strobe returns high. Random stimulus only picks which access comes next, the data values and whether a conversion is running. It never shortens the hold times.

// File: rtl/pbi_pkg.sv
package pbi_pkg;
  localparam int CTRL_W   = 10;
  localparam int DUAL_BIT = 6;
  localparam int INT_BIT  = 9;

  // strobes from the control side to the datapath
  typedef struct packed {
    logic load;
    logic toggle;
    logic clearFlag;
  } strobe_t;
endpackage

// File: rtl/pbi_strobe_ctrl.sv
module pbi_strobe_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             wrN,
  input  logic             rdN,
  input  logic             dualMode,
  input  logic             convActive,
  output pbi_pkg::strobe_t strb,
  output logic             startReq,
  output logic             abortReq
);
  localparam int LAST = SYNC_STAGES - 1;

  // bit 0 select, bit 1 write, bit 2 read
  logic [2:0] stage [SYNC_STAGES];
  logic [2:0] prevPins;

  genvar g;
  for (g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stage[0] <= 3'b111;
        else       stage[0] <= {rdN, wrN, csN};
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stage[g] <= 3'b111;
        else       stage[g] <= stage[g-1];
    end
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) prevPins <= 3'b111;
    else       prevPins <= stage[LAST];

  logic [2:0] curPins;
  logic       selected, wrRise, wrFall, rdRise, rdFall, accessFall, abortNow;

  always_comb begin
    curPins    = stage[LAST];
    selected   = ~curPins[0];
    wrRise     = selected &  curPins[1] & ~prevPins[1];
    wrFall     = selected & ~curPins[1] &  prevPins[1];
    rdRise     = selected &  curPins[2] & ~prevPins[2];
    rdFall     = selected & ~curPins[2] &  prevPins[2];
    accessFall = wrFall | rdFall;
    abortNow   = accessFall & convActive;
    strb.load      = wrRise;
    strb.toggle    = rdRise & dualMode;
    strb.clearFlag = accessFall;
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      startReq <= 1'b0;
      abortReq <= 1'b0;
    end else begin
      startReq <= wrRise;
      abortReq <= abortNow;
    end
endmodule

// File: rtl/pbi_datapath.sv
module pbi_datapath #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  pbi_pkg::strobe_t  strb,
  input  logic              csN,
  input  logic              rdN,
  input  logic [DATA_W-1:0] busIn,
  input  logic              convActive,
  input  logic              convDone,
  input  logic [DATA_W-1:0] result1,
  input  logic [DATA_W-1:0] result2,
  output logic [DATA_W-1:0] ctrlReg,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic              flagN
);
  logic readPtr;
  logic intPending;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) ctrlReg <= '0;
    else if (strb.load) ctrlReg <= busIn;

  // a write resets the pointer; a finished dual-mode read flips it
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)            readPtr <= 1'b0;
    else if (strb.load)   readPtr <= 1'b0;
    else if (strb.toggle) readPtr <= ~readPtr;

  // completion wins over a clear arriving in the same cycle
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)               intPending <= 1'b0;
    else if (convDone)       intPending <= 1'b1;
    else if (strb.clearFlag) intPending <= 1'b0;

  always_comb begin
    busOe  = ~csN & ~rdN;
    busOut = (ctrlReg[pbi_pkg::DUAL_BIT] & readPtr) ? result2 : result1;
    flagN  = ctrlReg[pbi_pkg::INT_BIT] ? ~intPending : ~convActive;
  end
endmodule

// File: rtl/parbus_host_if.sv
module parbus_host_if #(
  parameter int DATA_W      = pbi_pkg::CTRL_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              wrN,
  input  logic              rdN,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  input  logic              convActive,
  input  logic              convDone,
  input  logic [DATA_W-1:0] result1,
  input  logic [DATA_W-1:0] result2,
  output logic [DATA_W-1:0] ctrlReg,
  output logic              startReq,
  output logic              abortReq,
  output logic              flagN
);
  pbi_pkg::strobe_t strb;

  pbi_strobe_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .rdN(rdN),
    .dualMode(ctrlReg[pbi_pkg::DUAL_BIT]), .convActive(convActive),
    .strb(strb), .startReq(startReq), .abortReq(abortReq)
  );

  pbi_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .csN(csN), .rdN(rdN),
    .busIn(busIn), .convActive(convActive), .convDone(convDone),
    .result1(result1), .result2(result2), .ctrlReg(ctrlReg),
    .busOut(busOut), .busOe(busOe), .flagN(flagN)
  );
endmodule

// File: rtl/pbi_checker.sv
module pbi_checker #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rstN,
  input logic         startReq,
  input logic         abortReq,
  input logic         convActive,
  input logic         convDone,
  input logic         flagN,
  input logic [W-1:0] ctrlReg
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> !startReq); // R2
  AST_CTRL_ONLY_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    !startReq |-> $stable(ctrlReg)); // R2
  AST_ABORT_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |-> $past(convActive)); // R9
  AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> !abortReq); // R9
  AST_NO_START_WITH_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    !(startReq && abortReq)); // R9
  AST_INT_FALL_FROM_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[9] && $past(ctrlReg[9]) && $fell(flagN)) |-> $past(convDone)); // R7
endmodule

bind parbus_host_if pbi_checker #(.W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .startReq(startReq), .abortReq(abortReq),
  .convActive(convActive), .convDone(convDone), .flagN(flagN), .ctrlReg(ctrlReg)
);

// File: tb/tb_parbus_host_if.sv
`timescale 1ns/1ps
module tb_parbus_host_if;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, wrN = 1'b1, rdN = 1'b1;
  logic [9:0] busIn = '0;
  logic [9:0] busOut;
  logic busOe;
  logic convActive = 1'b0, convDone = 1'b0;
  logic [9:0] result1 = 10'h123, result2 = 10'h2AB;
  logic [9:0] ctrlReg;
  logic startReq, abortReq, flagN;

  always #2.5 clk = ~clk;

  parbus_host_if dut (.*);

  int errors = 0, checks = 0;
  int startCnt = 0, abortCnt = 0;
  int expStart = 0, expAbort = 0;
  logic [9:0] expCtrl = '0;
  logic expPtr = 1'b0;
  bit finished = 1'b0;

  always @(posedge clk) begin
    if (startReq) startCnt++;
    if (abortReq) abortCnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [9:0] expRead();
    return (expCtrl[6] && expPtr) ? result2 : result1;
  endfunction

  task automatic busWrite(input logic [9:0] d);
    @(negedge clk); busIn = d; csN = 1'b0;
    idle(1); wrN = 1'b0;
    idle(5); wrN = 1'b1;
    idle(5); csN = 1'b1;
    idle(2);
    expCtrl = d; expPtr = 1'b0; expStart++;
    if (convActive) expAbort++;
  endtask

  task automatic busRead(input string req);
    logic [9:0] e;
    e = expRead();
    @(negedge clk); csN = 1'b0;
    idle(1); rdN = 1'b0;
    idle(2);
    chk({req, " data"}, busOut, e);
    chk("R4 oe", busOe, 1);
    idle(3); rdN = 1'b1;
    idle(5); csN = 1'b1;
    idle(2);
    if (expCtrl[6]) expPtr = ~expPtr;
    if (convActive) expAbort++;
  endtask

  initial begin
    int wd = 0;
    while (!finished && wd < 100000) begin @(posedge clk); wd++; end
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", wd);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    idle(3); rstN = 1'b1; idle(2);
    // R1 reset state
    chk("R1 ctrl", ctrlReg, 0);
    chk("R1 flag", flagN, 1);
    chk("R1 oe", busOe, 0);

    // R2 write loads and starts
    busWrite(10'h0A5);
    chk("R2 ctrl", ctrlReg, 10'h0A5);
    chk("R2 start", startCnt, expStart);

    // R5 single mode keeps returning result 1
    busRead("R5 first");
    busRead("R5 second");

    // R3 strobes ignored while select high
    @(negedge clk); busIn = 10'h3FF; wrN = 1'b0; idle(5); wrN = 1'b1; idle(6);
    chk("R3 ctrl", ctrlReg, expCtrl);
    chk("R3 start", startCnt, expStart);
    rdN = 1'b0; idle(2);
    chk("R3 oe", busOe, 0);
    rdN = 1'b1; idle(6);

    // R6 dual-mode alternation and pointer reset on write
    busWrite(10'h040);
    busRead("R6 r1");
    busRead("R6 r2");
    busRead("R6 r1 again");
    busWrite(10'h040);
    busRead("R6 after write");

    // R8 busy mode follows conversion activity
    busWrite(10'h000);
    convActive = 1'b1; idle(1);
    chk("R8 active", flagN, 0);
    convActive = 1'b0; idle(1);
    chk("R8 idle", flagN, 1);

    // R9 abort on access during conversion, none when idle
    convActive = 1'b1;
    busRead("R9 read");
    chk("R9 abort read", abortCnt, expAbort);
    busWrite(10'h011);
    chk("R9 abort write", abortCnt, expAbort);
    chk("R9 start write", startCnt, expStart);
    convActive = 1'b0;
    busRead("R9 idle read");
    chk("R9 no abort", abortCnt, expAbort);

    // R7 interrupt mode
    busWrite(10'h200);
    chk("R7 initial", flagN, 1);
    @(negedge clk); convDone = 1'b1; @(negedge clk); convDone = 1'b0;
    idle(2);
    chk("R7 set", flagN, 0);
    busRead("R7 read");
    chk("R7 cleared", flagN, 1);

    // random mix
    for (int it = 0; it < 60; it++) begin
      int op;
      op = $urandom % 4;
      convActive = (($urandom % 4) == 0);
      idle(1);
      case (op)
        0: busWrite(10'($urandom));
        1, 2: busRead(expCtrl[6] ? "R6 rand" : "R5 rand");
        default: begin result1 = 10'($urandom); result2 = 10'($urandom); idle(1); end
      endcase
      if (!expCtrl[9]) chk("R8 rand", flagN, !convActive);
      chk("R2 rand ctrl", ctrlReg, expCtrl);
    end
    convActive = 1'b0; idle(3);
    chk("R2 total starts", startCnt, expStart);
    chk("R9 total aborts", abortCnt, expAbort);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule